// File: doc/BRIEF.md
# Register-Access Bitmap Gate

This block sits beside a guest execution pipeline. For every guest read or write of a model-specific register, it decides whether the access may go straight through or must trap to the hypervisor. A request carries a 32-bit register index and a direction flag. The hypervisor supplies two more inputs: an enable that turns bitmap consultation on, and the physical base of a one-page permission bitmap.

Only two slices of the index space can be looked up:
- the low window, indices 0x00000000 to 0x00001FFF;
- the high window, indices 0xC0000000 to 0xC0001FFF.

The page is cut into four 1 KB quarters, selected by direction and window. The gate forms the byte address of the permission bit and fetches that byte over a simple request/valid read port. A set bit means trap; a clear bit means allow. When the outcome is already fixed by the request, no fetch is made. That happens when the enable is off, the index lies outside both windows, or the base is not page aligned; each of these traps.

One request is handled at a time. A busy flag covers the whole transaction, and the verdict is presented for exactly one cycle with a reason code that tells read traps from write traps.

Top module: `regperm_gate`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `mem_req_o` and `dec_valid_o` are 0.
- R2: For an accepted request that needs a lookup, the byte address is the base with bits [11:0] replaced as follows: bit 11 is the write flag, bit 10 is 1 for the high window, and bits [9:0] are index bits [12:3]. The tested bit within that byte is index bits [2:0].
- R3: After a lookup, a tested bit of 1 gives a trap and a tested bit of 0 gives an allow.
- R4: With `bm_enable_i` at 0, every request traps and no memory read is issued.
- R5: An index in neither window (index bits [31:13] neither 0 nor 0x60000) traps without a memory read, even with the enable at 1.
- R6: A base with any of bits [11:0] nonzero makes the request trap without a memory read.
- R7: `dec_reason_o` is 2'b00 on allow, 2'b01 on a read that traps, and 2'b10 on a write that traps.
- R8: `busy_o` rises the cycle after acceptance and stays high up to and including the decision cycle. `req_valid_i` pulses while busy are ignored: they change neither the pending verdict nor the number of decisions.
- R9: `dec_valid_o` is high for exactly one cycle per accepted request. For a request that traps without a lookup, that cycle is the one right after acceptance.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until a cycle in which `mem_valid_i` is sampled high. The decision follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, accepted when idle |
| req_idx_i | input | 32 | Register index of the access |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| bm_enable_i | input | 1 | Consult bitmap when 1; trap everything when 0 |
| bm_base_i | input | 40 | Physical base of the permission page |
| busy_o | output | 1 | Transaction in progress |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 40 | Byte address of the read |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| dec_valid_o | output | 1 | Verdict valid (one cycle) |
| dec_exit_o | output | 1 | 1 = trap, 0 = allow |
| dec_reason_o | output | 2 | 00 allow, 01 read trap, 10 write trap |

## Verification
The bound checker watches several rules on every cycle:
- the verdict is a one-cycle pulse that never appears outside busy;
- once busy is raised, it is held until the verdict;
- the reason code agrees with the trap flag;
- a pending memory request keeps its address until data returns;
- a memory request only occurs while busy.

Other behaviour depends on the data and on the request itself, so only the bench scenarios can show it:
- which bit of which quarter gets tested;
- whether a disabled, out-of-window or misaligned request really skips the fetch;
- whether stray strobes during a transaction are ignored.

The bench compares all of this against its own address and verdict model, with random memory latency.

// File: rtl/regperm_pkg.sv
package regperm_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'b00,
    RSN_READ  = 2'b01,
    RSN_WRITE = 2'b10
  } reason_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_DONE  = 2'b10
  } state_e;

  typedef struct packed {
    logic in_low;
    logic in_high;
  } win_t;
endpackage

// File: rtl/regperm_window.sv
module regperm_window
  import regperm_pkg::*;
#(
  parameter int          IDX_W     = 32,
  parameter int          WIN_BITS  = 13,
  parameter logic [31:0] HIGH_BASE = 32'hC000_0000
) (
  input  logic [IDX_W-WIN_BITS-1:0] tag_i,
  output win_t                      win_o
);
  localparam int TAG_W = IDX_W - WIN_BITS;
  localparam logic [TAG_W-1:0] HIGH_TAG = HIGH_BASE[IDX_W-1:WIN_BITS];

  // Only the tag above the window span decides membership.
  always_comb begin
    win_o.in_low  = (tag_i == '0);
    win_o.in_high = (tag_i == HIGH_TAG);
  end
endmodule

// File: rtl/regperm_addr.sv
module regperm_addr #(
  parameter int ADDR_W    = 40,
  parameter int PAGE_BITS = 12,
  parameter int SLOT_BITS = 10
) (
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [SLOT_BITS-1:0] slot_i,
  input  logic                 write_i,
  input  logic                 high_i,
  output logic [ADDR_W-1:0]    byte_addr_o,
  output logic                 base_ok_o
);
  localparam int QSEL_BITS = PAGE_BITS - SLOT_BITS;

  logic [QSEL_BITS-1:0] quarter;

  // Quarter select: write half above read half, high window above low window.
  always_comb begin
    quarter     = {write_i, high_i};
    byte_addr_o = {base_i[ADDR_W-1:PAGE_BITS], quarter, slot_i};
    base_ok_o   = (base_i[PAGE_BITS-1:0] == '0);
  end
endmodule

// File: rtl/regperm_ctrl.sv
module regperm_ctrl
  import regperm_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              forced_i,
  input  logic              write_i,
  input  logic [2:0]        bit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              dec_valid_o,
  output logic              dec_exit_o,
  output logic [1:0]        dec_reason_o
);
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              wr_q;
  logic              exit_q, exit_d, exit_en;
  logic              accept;
  reason_e           reason;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = forced_i ? ST_DONE : ST_FETCH;
      ST_FETCH: if (mem_valid_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    exit_en = 1'b0;
    exit_d  = exit_q;
    if (accept) begin
      exit_en = 1'b1;
      exit_d  = forced_i;
    end else if ((state_q == ST_FETCH) && mem_valid_i) begin
      exit_en = 1'b1;
      exit_d  = mem_data_i[bit_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      wr_q    <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_i;
        bit_q  <= bit_i;
        wr_q   <= write_i;
      end
      if (exit_en) exit_q <= exit_d;
    end
  end

  always_comb begin
    if (!exit_q)   reason = RSN_NONE;
    else if (wr_q) reason = RSN_WRITE;
    else           reason = RSN_READ;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign mem_req_o    = (state_q == ST_FETCH);
  assign mem_addr_o   = addr_q;
  assign dec_valid_o  = (state_q == ST_DONE);
  assign dec_exit_o   = dec_valid_o && exit_q;
  assign dec_reason_o = dec_valid_o ? reason : RSN_NONE;
endmodule

// File: rtl/regperm_gate.sv
module regperm_gate
  import regperm_pkg::*;
#(
  parameter int          ADDR_W    = 40,
  parameter int          IDX_W     = 32,
  parameter int          WIN_BITS  = 13,
  parameter int          PAGE_BITS = 12,
  parameter logic [31:0] HIGH_BASE = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              req_write_i,
  input  logic              bm_enable_i,
  input  logic [ADDR_W-1:0] bm_base_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              dec_valid_o,
  output logic              dec_exit_o,
  output logic [1:0]        dec_reason_o
);
  localparam int SLOT_BITS = WIN_BITS - 3;

  win_t              win;
  logic [ADDR_W-1:0] byte_addr;
  logic              base_ok;
  logic              forced;

  regperm_window #(
    .IDX_W(IDX_W), .WIN_BITS(WIN_BITS), .HIGH_BASE(HIGH_BASE)
  ) u_win (
    .tag_i (req_idx_i[IDX_W-1:WIN_BITS]),
    .win_o (win)
  );

  regperm_addr #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SLOT_BITS(SLOT_BITS)
  ) u_addr (
    .base_i      (bm_base_i),
    .slot_i      (req_idx_i[WIN_BITS-1:3]),
    .write_i     (req_write_i),
    .high_i      (win.in_high),
    .byte_addr_o (byte_addr),
    .base_ok_o   (base_ok)
  );

  // Verdict fixed without memory: disabled, outside windows, or bad base.
  assign forced = !bm_enable_i || !(win.in_low || win.in_high) || !base_ok;

  regperm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .forced_i     (forced),
    .write_i      (req_write_i),
    .bit_i        (req_idx_i[2:0]),
    .addr_i       (byte_addr),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_valid_i  (mem_valid_i),
    .mem_data_i   (mem_data_i),
    .dec_valid_o  (dec_valid_o),
    .dec_exit_o   (dec_exit_o),
    .dec_reason_o (dec_reason_o)
  );
endmodule

// File: rtl/regperm_check.sv
module regperm_check #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              dec_valid_o,
  input logic              dec_exit_o,
  input logic [1:0]        dec_reason_o
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !mem_req_o && !dec_valid_o));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_decide_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i) |=> dec_valid_o);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> !dec_valid_o);

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o || mem_req_o) |-> busy_o);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !dec_valid_o) |=> busy_o);

  p_allow_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_exit_o) |-> (dec_reason_o == 2'b00));

  p_exit_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && dec_exit_o) |-> (dec_reason_o == 2'b01 || dec_reason_o == 2'b10));
endmodule

bind regperm_gate regperm_check #(.ADDR_W(ADDR_W)) u_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_valid_i  (mem_valid_i),
  .dec_valid_o  (dec_valid_o),
  .dec_exit_o   (dec_exit_o),
  .dec_reason_o (dec_reason_o)
);

// File: tb/regperm_gate_tb_top.sv
`timescale 1ns/1ps
module regperm_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_idx_i = '0;
  logic        req_write_i = 1'b0;
  logic        bm_enable_i = 1'b0;
  logic [39:0] bm_base_i = '0;
  logic        busy_o, mem_req_o, dec_valid_o, dec_exit_o;
  logic [39:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic [1:0]  dec_reason_o;

  int checks = 0;
  int failures = 0;
  int grants = 0;
  int wait_cnt = 0;
  logic [39:0] seen_addr = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regperm_gate dut_i (.*);

  function automatic logic [7:0] mbyte(input logic [39:0] a);
    return (a[7:0] * 8'hA7) ^ a[19:12] ^ {a[11:8], a[11:8]} ^ 8'h5C;
  endfunction

  // Memory responder: random latency 0..3 cycles, one-cycle valid pulse.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid_i = 1'b0;
      wait_cnt    = 0;
    end else if (mem_valid_i) begin
      mem_valid_i = 1'b0;
      wait_cnt    = $urandom % 4;
    end else if (mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_valid_i = 1'b1;
        mem_data_i  = mbyte(mem_addr_o);
        seen_addr   = mem_addr_o;
        grants++;
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] idx, input bit wr, input bit en,
                         input logic [39:0] base, input bit stray);
    bit          low, high, forced, exp_exit;
    logic [39:0] exp_addr;
    logic [1:0]  exp_rsn;
    int          g0, lat;
    string       tag;
    low      = (idx[31:13] == 19'h0);
    high     = (idx[31:13] == 19'h60000);
    forced   = !en || !(low || high) || (base[11:0] != 12'h0);
    exp_addr = base + (wr ? 40'h800 : 40'h0) + (high ? 40'h400 : 40'h0) + 40'(idx[12:3]);
    exp_exit = forced ? 1'b1 : mbyte(exp_addr)[idx[2:0]];
    exp_rsn  = !exp_exit ? 2'b00 : (wr ? 2'b10 : 2'b01);
    tag      = !en ? "R4" : (!(low || high) ? "R5" : ((base[11:0] != 0) ? "R6" : "R3"));
    g0 = grants;
    @(negedge clk);
    req_idx_i = idx; req_write_i = wr; bm_enable_i = en; bm_base_i = base;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 1;
    if (stray) begin
      req_valid_i = 1'b1; req_idx_i = ~idx; req_write_i = ~wr;
    end
    while (!dec_valid_o && lat < 40) begin
      check(busy_o === 1'b1, "R8", "busy while pending", busy_o, 1);
      @(negedge clk);
      req_valid_i = 1'b0;
      lat++;
    end
    req_valid_i = 1'b0;
    check(dec_valid_o === 1'b1, "R9", "decision arrives", dec_valid_o, 1);
    check(busy_o === 1'b1, "R8", "busy in decision cycle", busy_o, 1);
    check(dec_exit_o === exp_exit, tag, "exit verdict", dec_exit_o, exp_exit);
    check(dec_reason_o === exp_rsn, "R7", "reason code", dec_reason_o, exp_rsn);
    if (forced) begin
      check(grants == g0, tag, "no memory read", grants - g0, 0);
      check(lat == 1, "R9", "forced latency", lat, 1);
    end else begin
      check(grants == g0 + 1, "R2", "one memory read", grants - g0, 1);
      check(seen_addr === exp_addr, "R2", "byte address", seen_addr, exp_addr);
    end
    @(negedge clk);
    check(dec_valid_o === 1'b0, "R9", "single pulse", dec_valid_o, 0);
    check(busy_o === 1'b0, "R8", "idle after decision", busy_o, 0);
    if (stray) check(grants == g0 + (forced ? 0 : 1), "R8", "stray strobe ignored", grants - g0, 0);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] idx;
    logic [39:0] base;
    int          r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && mem_req_o === 1'b0 && dec_valid_o === 1'b0,
          "R1", "outputs in reset", {busy_o, mem_req_o, dec_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && mem_req_o === 1'b0 && dec_valid_o === 1'b0,
          "R1", "outputs after reset", {busy_o, mem_req_o, dec_valid_o}, 0);
    // Directed corners
    run_req(32'h0000_0000, 1'b0, 1'b1, 40'h12_3456_7000, 1'b0);
    run_req(32'h0000_1FFF, 1'b1, 1'b1, 40'h12_3456_7000, 1'b0);
    run_req(32'hC000_0000, 1'b0, 1'b1, 40'h00_0ABC_D000, 1'b0);
    run_req(32'hC000_1FFF, 1'b1, 1'b1, 40'h00_0ABC_D000, 1'b0);
    run_req(32'h0000_2000, 1'b0, 1'b1, 40'h00_0000_1000, 1'b0);
    run_req(32'hBFFF_FFFF, 1'b1, 1'b1, 40'h00_0000_1000, 1'b0);
    run_req(32'hC000_2000, 1'b1, 1'b1, 40'h00_0000_1000, 1'b0);
    run_req(32'h0000_0010, 1'b0, 1'b0, 40'h00_0000_1000, 1'b0);
    run_req(32'hC000_0010, 1'b1, 1'b0, 40'h00_0000_1000, 1'b0);
    run_req(32'h0000_0010, 1'b1, 1'b1, 40'h00_0000_1800, 1'b0);
    run_req(32'h0000_0123, 1'b0, 1'b1, 40'h00_0000_5000, 1'b1);
    run_req(32'h0000_0123, 1'b1, 1'b0, 40'h00_0000_5000, 1'b1);
    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      r = $urandom % 10;
      if (r < 4)      idx = {19'h0, 13'($urandom)};
      else if (r < 8) idx = {19'h60000, 13'($urandom)};
      else            idx = $urandom;
      base = {28'($urandom), 12'h000};
      if ($urandom % 10 == 0) base[11:0] = 12'($urandom) | 12'h001;
      run_req(idx, 1'($urandom), ($urandom % 10) != 0, base, ($urandom % 5) == 0);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule